// File: doc/BRIEF.md
# Three-Wire Serial Programming Register Bank

This block lets a host microcontroller write a small bank of control words over a write-only three-wire port: a serial data line, a serial clock and an enable strobe. The words hold reference counter values, receive and transmit channel divider values, and control bits for the surrounding synthesizer logic. Nothing is ever driven back to the host.

The three serial lines are oversampled by the fast system clock through two-flop synchronizers, and all edge detection happens in that domain. While the enable is high, each falling edge of the serial clock shifts one data bit into an 18-bit shift register. A frame carries a 15-bit payload, most significant bit first, followed by a 3-bit word address that ends with its least significant bit. When the enable falls, the payload is copied into the addressed word, provided that exactly 18 falling edges were counted. The parallel contents of all six words are the block's only outputs.

Top module: `ser_prog_bank`

## Requirements
- R1: After reset, all six words read zero.
- R2: A frame's first 15 bits, sent most significant bit first, form the payload. Its last 3 bits are the address, with the address LSB last. Word k occupies output bits [15k+14:15k].
- R3: Bits are taken only on falling edges of the serial clock. Rising edges shift nothing.
- R4: A committed frame changes only the word its address selects. The other five keep their values.
- R5: Address codes 6 and 7 select no word, and a frame that carries either one changes nothing.
- R6: A frame with fewer than 18 falling edges is discarded when the enable falls.
- R7: A frame with more than 18 falling edges is discarded when the enable falls.
- R8: While the enable is low, the bit count and the shift contents are cleared, so a frame that follows an aborted one is decoded from its first bit.
- R9: Serial clock edges that arrive while the enable is low have no effect.
- R10: A serial clock falling edge that the synchronizers see in the same system cycle as the enable's falling edge is not counted as a bit.
- R11: The written word appears on the outputs on the third rising system clock edge after the enable input falls. After the second edge it still shows its old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, used to oversample the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ser_data_i | input | 1 | Serial data from the host |
| ser_clk_i | input | 1 | Serial bit clock from the host; bits are taken on its falling edge |
| ser_en_i | input | 1 | Frame enable, active high; its falling edge ends the frame |
| words_o | output | 90 | Six 15-bit words, concatenated with word 0 in the lowest bits |

## Verification
The closing falling edge of the serial clock and the falling edge of the enable can land in the same synchronized system cycle. At that point the block must decide whether the edge counts as a bit before it judges the frame length. The bench provokes this by dropping both lines at the same instant. In one case the coincident edge would have been bit 18, so the frame is expected to be discarded. In the other case 18 bits came before the coincident extra edge, so the frame is expected to commit. In both cases the scoreboard compares all six words against its model.

// File: rtl/spb_pkg.sv
package spb_pkg;
  localparam int unsigned SPB_DATA_W    = 15;
  localparam int unsigned SPB_ADDR_W    = 3;
  localparam int unsigned SPB_NUM_WORDS = 6;
  localparam int unsigned SPB_FRAME_W   = SPB_DATA_W + SPB_ADDR_W;
endpackage

// File: rtl/spb_sync.sv
module spb_sync #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/spb_shifter.sv
module spb_shifter #(
  parameter int unsigned DATA_W = 15,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sdat_s_i,
  input  logic              sclk_s_i,
  input  logic              en_s_i,
  output logic              commit_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned FW    = DATA_W + ADDR_W;
  localparam int unsigned CNT_W = $clog2(FW + 2);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(FW + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FW);

  logic          sclk_q, en_q;
  logic [FW-1:0] shreg_q, shreg_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic          sclk_fall, en_fall;

  assign sclk_fall = sclk_q & ~sclk_s_i;
  assign en_fall   = en_q & ~en_s_i;

  always_comb begin
    shreg_n = shreg_q;
    cnt_n   = cnt_q;
    if (!en_s_i) begin
      shreg_n = '0;
      cnt_n   = '0;
    end else if (sclk_fall) begin
      shreg_n = {shreg_q[FW-2:0], sdat_s_i};
      if (cnt_q != CNT_MAX) cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      en_q    <= 1'b0;
      shreg_q <= '0;
      cnt_q   <= '0;
    end else begin
      sclk_q  <= sclk_s_i;
      en_q    <= en_s_i;
      shreg_q <= shreg_n;
      cnt_q   <= cnt_n;
    end
  end

  assign commit_o = en_fall && (cnt_q == CNT_FULL);
  assign addr_o   = shreg_q[ADDR_W-1:0];
  assign data_o   = shreg_q[FW-1:ADDR_W];

  // R8
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_s_i |=> (cnt_q == '0) && (shreg_q == '0));

  // R3
  rise_noshift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_s_i && !sclk_q && sclk_s_i) |=> $stable(shreg_q));

  // R7
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX);
endmodule

// File: rtl/spb_bank.sv
module spb_bank #(
  parameter int unsigned DATA_W    = 15,
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned NUM_WORDS = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        commit_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [DATA_W-1:0]           data_i,
  output logic [NUM_WORDS*DATA_W-1:0] words_o
);
  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    logic              wr_en;
    logic [DATA_W-1:0] word_q, word_n;

    assign wr_en = commit_i && (addr_i == ADDR_W'(i));

    always_comb begin
      word_n = word_q;
      if (wr_en) word_n = data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= '0;
      else        word_q <= word_n;
    end

    assign words_o[i*DATA_W +: DATA_W] = word_q;

    // R2
    word_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_i && addr_i == ADDR_W'(i)) |=> word_q == $past(data_i));
  end

  // R4
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> $stable(words_o));

  // R5
  unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && addr_i >= ADDR_W'(NUM_WORDS)) |=> $stable(words_o));
endmodule

// File: rtl/ser_prog_bank.sv
module ser_prog_bank
  import spb_pkg::*;
#(
  parameter int unsigned DATA_W    = SPB_DATA_W,
  parameter int unsigned ADDR_W    = SPB_ADDR_W,
  parameter int unsigned NUM_WORDS = SPB_NUM_WORDS
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ser_data_i,
  input  logic                        ser_clk_i,
  input  logic                        ser_en_i,
  output logic [NUM_WORDS*DATA_W-1:0] words_o
);
  logic [2:0]        sync_q;
  logic              commit;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] data;

  spb_sync #(.W(3)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({ser_data_i, ser_clk_i, ser_en_i}),
    .q_o   (sync_q)
  );

  spb_shifter #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .sdat_s_i (sync_q[2]),
    .sclk_s_i (sync_q[1]),
    .en_s_i   (sync_q[0]),
    .commit_o (commit),
    .addr_o   (addr),
    .data_o   (data)
  );

  spb_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .commit_i (commit),
    .addr_i   (addr),
    .data_i   (data),
    .words_o  (words_o)
  );
endmodule

// File: tb/tb_ser_prog_bank.sv
module tb_ser_prog_bank;
  localparam int DW = 15;
  localparam int NW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sdat = 1'b0, sclk = 1'b0, sen = 1'b0;
  logic [NW*DW-1:0] words;

  int total = 0;
  int bad = 0;
  logic [DW-1:0] model [NW];
  logic [NW*DW-1:0] exp_q [$];
  string tag_q [$];
  bit done = 0;

  always #4 clk = ~clk;

  ser_prog_bank dut (
    .clk(clk), .rst_n(rst_n), .ser_data_i(sdat), .ser_clk_i(sclk),
    .ser_en_i(sen), .words_o(words)
  );

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [NW*DW-1:0] pack_model();
    logic [NW*DW-1:0] v;
    for (int i = 0; i < NW; i++) v[i*DW +: DW] = model[i];
    return v;
  endfunction

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Send nbits of {data,addr}, extra bits zero. If coinc, the last falling
  // edge is made together with the enable fall.
  task automatic send_frame(input logic [2:0] addr, input logic [DW-1:0] data,
                            input int nbits, input bit coinc, input string tag);
    logic [17:0] fr;
    int counted;
    fr = {data, addr};
    @(negedge clk);
    sen = 1'b1;
    wait_cyc(4);
    for (int b = 0; b < nbits; b++) begin
      sdat = (b < 18) ? fr[17-b] : 1'b0;
      sclk = 1'b1;
      wait_cyc(4);
      if (coinc && b == nbits - 1) begin
        sclk = 1'b0; sen = 1'b0;
      end else begin
        sclk = 1'b0;
        wait_cyc(4);
      end
    end
    sen = 1'b0;
    counted = coinc ? nbits - 1 : nbits;
    if (counted == 18 && addr < 3'(NW)) model[addr] = data;
    wait_cyc(8);
    exp_q.push_back(pack_model());
    tag_q.push_back(tag);
    wait_cyc(2);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        logic [NW*DW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        for (int i = 0; i < NW; i++)
          chk(words[i*DW +: DW] == e[i*DW +: DW], t, words[i*DW +: DW], e[i*DW +: DW]);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NW; i++) model[i] = '0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
    // R1 reset state
    exp_q.push_back(pack_model()); tag_q.push_back("R1 reset");
    wait_cyc(2);
    // R2 R4 basic writes
    send_frame(3'd0, 15'h5A3C, 18, 0, "R2 word0");
    send_frame(3'd5, 15'h7FFF, 18, 0, "R2 word5");
    send_frame(3'd3, 15'h0001, 18, 0, "R4 word3 others kept");
    send_frame(3'd1, 15'h4000, 18, 0, "R2 msb first word1");
    // R5 unmapped
    send_frame(3'd6, 15'h1234, 18, 0, "R5 addr6");
    send_frame(3'd7, 15'h2345, 18, 0, "R5 addr7");
    // R6 short, R7 long
    send_frame(3'd2, 15'h3333, 17, 0, "R6 short frame");
    send_frame(3'd2, 15'h3333, 19, 0, "R7 long frame");
    // R8 aborted frame then good frame
    send_frame(3'd4, 15'h1111, 10, 0, "R8 aborted");
    send_frame(3'd4, 15'h2AAA, 18, 0, "R8 fresh frame");
    // R9 clock toggles with enable low
    for (int k = 0; k < 6; k++) begin
      sdat = k[0]; sclk = 1'b1; wait_cyc(4); sclk = 1'b0; wait_cyc(4);
    end
    exp_q.push_back(pack_model()); tag_q.push_back("R9 idle clocks");
    wait_cyc(2);
    send_frame(3'd2, 15'h6B5D, 18, 0, "R9 frame after idle clocks");
    // R10 coincidence
    send_frame(3'd0, 15'h0F0F, 18, 1, "R10 coincident 18th edge dropped");
    send_frame(3'd0, 15'h70F1, 19, 1, "R10 coincident 19th edge dropped");
    // R3: extra rising edge before frame start has no effect
    @(negedge clk); sen = 1'b1; wait_cyc(4);
    sclk = 1'b1; wait_cyc(4); sen = 1'b0; wait_cyc(4); sclk = 1'b0; wait_cyc(8);
    exp_q.push_back(pack_model()); tag_q.push_back("R3 rising edge only");
    wait_cyc(2);
    // R11 latency, directed
    begin
      logic [17:0] fr;
      fr = {15'h1357, 3'd1};
      @(negedge clk); sen = 1'b1; wait_cyc(4);
      for (int b = 0; b < 18; b++) begin
        sdat = fr[17-b]; sclk = 1'b1; wait_cyc(4); sclk = 1'b0; wait_cyc(4);
      end
      sen = 1'b0;
      @(posedge clk); @(posedge clk); @(negedge clk);
      chk(words[1*DW +: DW] == model[1], "R11 old value after two edges",
          words[1*DW +: DW], model[1]);
      @(posedge clk); @(negedge clk);
      chk(words[1*DW +: DW] == 15'h1357, "R11 new value after three edges",
          words[1*DW +: DW], 15'h1357);
      model[1] = 15'h1357;
    end
    wait_cyc(4);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule